// File: doc/BRIEF.md
# Recursive Vertical-and-Crosswise Unsigned Multiplier

This block multiplies two unsigned operands of `WIDTH` bits (16 by default) and returns their full product of `2*WIDTH` bits. It is purely combinational: there is no clock, no reset and no stored state. The product follows any change of the operands once the logic has settled.

The structure is recursive. At each level both operands are split into an upper half and a lower half. Four half-width multipliers form the low-by-low, high-by-low, low-by-high and high-by-high sub-products.

- The lower half of the low-by-low product passes straight into the lowest result bits.
- One ripple-carry adder sums the two cross products.
- A second ripple-carry adder adds the upper half of the low-by-low product to that sum.
- A final ripple-carry adder places the high-by-high product on top, offset by half a width, and forms the upper result bits.

The recursion stops at a gate-level 2x2 cell. As a result, any power-of-two `WIDTH` of 2 or more builds the same arrangement at every level.

Top module: `vedic_mul`

## Requirements
- R1: For every pair of 16-bit operands, `prod` equals the unsigned product `op_a * op_b`.
- R2: The block holds no state: after an operand change, `prod` shows the new product without any clock edge, and earlier operands leave no trace.
- R3: When either operand is zero, `prod` is zero.
- R4: When one operand is one, `prod` equals the other operand zero-extended to `2*WIDTH` bits.
- R5: Bit 0 of `prod` equals the AND of bit 0 of both operands.
- R6: When both operands are below 2^(WIDTH/2), the upper `WIDTH` bits of `prod` are zero.
- R7: Carries reach the top bit: all-ones times all-ones gives 0xFFFE0001 at WIDTH=16.
- R8: With WIDTH set to 4 or 8, the block is exact for every operand pair.
- R9: With WIDTH set to 2, the base cell yields p0=a0&b0, p1=(a1&b0)^(a0&b1), and p2, p3 as the sum and carry of a1&b1 with the carry of p1, for all 16 operand pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Unsigned multiplicand |
| op_b | input | WIDTH | Unsigned multiplier |
| prod | output | 2*WIDTH | Unsigned full-width product |

## Verification
A wrong adder alignment or a broken carry link inside one level corrupts a band of product bits. It shows at the ports in the same evaluation as the operands that exercise it, since no register hides it. Faults in the deepest 2x2 cells appear for most operand values. A dropped carry between the middle and final adders appears only when the cross terms overflow, so the bench drives saturated operands and runs exhaustive sweeps at the narrower widths, where every carry path is reached.

// File: rtl/vm_pkg.sv
package vm_pkg;

    // Sum and carry of one full-adder bit slice.
    typedef struct packed {
        logic sum;
        logic cout;
    } fa_out_t;

    // Partial terms of the 2x2 base cell.
    typedef struct packed {
        logic t_ll;   // a0 & b0
        logic t_hl;   // a1 & b0
        logic t_lh;   // a0 & b1
        logic t_hh;   // a1 & b1
    } cell_terms_t;

    function automatic fa_out_t full_add(input logic x, input logic y, input logic ci);
        fa_out_t r;
        r.sum  = x ^ y ^ ci;
        r.cout = (x & y) | (x & ci) | (y & ci);
        return r;
    endfunction

    function automatic cell_terms_t cell_terms(input logic [1:0] a, input logic [1:0] b);
        cell_terms_t t;
        t.t_ll = a[0] & b[0];
        t.t_hl = a[1] & b[0];
        t.t_lh = a[0] & b[1];
        t.t_hh = a[1] & b[1];
        return t;
    endfunction

endpackage

// File: rtl/vm_rca.sv
module vm_rca #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s
);
    import vm_pkg::*;

    logic [W-1:0] cy;
    fa_out_t      slice [W];

    assign cy[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign slice[i] = full_add(x[i], y[i], cy[i]);
        assign s[i]     = slice[i].sum;
        if (i < W - 1) begin : g_link
            assign cy[i+1] = slice[i].cout;
        end
    end

    // Carry out of the top slice is never needed by callers: widths are
    // chosen so that the sum cannot overflow.
    logic top_cout_unused;
    assign top_cout_unused = slice[W-1].cout;

endmodule

// File: rtl/vm_cell2.sv
module vm_cell2 (
    input  logic [1:0] a,
    input  logic [1:0] b,
    output logic [3:0] p
);
    import vm_pkg::*;

    cell_terms_t t;
    logic        c1;

    assign t    = cell_terms(a, b);
    assign p[0] = t.t_ll;
    assign p[1] = t.t_hl ^ t.t_lh;
    assign c1   = t.t_hl & t.t_lh;
    assign p[2] = t.t_hh ^ c1;
    assign p[3] = t.t_hh & c1;

endmodule

// File: rtl/vm_node.sv
module vm_node #(
    parameter int W = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    if (W == 2) begin : g_leaf
        vm_cell2 u_cell (
            .a (a),
            .b (b),
            .p (p)
        );
    end else begin : g_split
        localparam int H  = W / 2;
        localparam int FW = 3 * H;        // width of result bits [2W-1:H]

        logic [W-1:0] pp_ll, pp_hl, pp_lh, pp_hh;
        logic [W:0]   cross_s;
        logic [W:0]   mid_s;
        logic [FW-1:0] upper_s;

        vm_node #(.W(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(pp_ll));
        vm_node #(.W(H)) u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(pp_hl));
        vm_node #(.W(H)) u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(pp_lh));
        vm_node #(.W(H)) u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(pp_hh));

        // First adder: the two cross products.
        vm_rca #(.W(W+1)) u_add_cross (
            .x ({1'b0, pp_hl}),
            .y ({1'b0, pp_lh}),
            .s (cross_s)
        );

        // Second adder: fold in the upper half of the low product.
        vm_rca #(.W(W+1)) u_add_mid (
            .x (cross_s),
            .y ({{(H+1){1'b0}}, pp_ll[W-1:H]}),
            .s (mid_s)
        );

        // Final adder: high product sits H bits up inside the upper field.
        vm_rca #(.W(FW)) u_add_final (
            .x ({{(FW-W-1){1'b0}}, mid_s}),
            .y ({pp_hh, {H{1'b0}}}),
            .s (upper_s)
        );

        assign p = {upper_s, pp_ll[H-1:0]};
    end

endmodule

// File: rtl/vedic_mul.sv
module vedic_mul #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic [2*WIDTH-1:0] prod
);
    localparam int PW = 2 * WIDTH;

    logic [PW-1:0] tree_p;

    vm_node #(.W(WIDTH)) u_tree (
        .a (op_a),
        .b (op_b),
        .p (tree_p)
    );

    assign prod = tree_p;

endmodule

// File: rtl/vedic_mul_chk.sv
module vedic_mul_chk #(
    parameter int W = 16
) (
    input logic [W-1:0]   op_a,
    input logic [W-1:0]   op_b,
    input logic [2*W-1:0] prod
);
    localparam int H = W / 2;

    always_comb begin
        // R3
        zero_operand_chk: assert (!((op_a == '0) || (op_b == '0)) || (prod == '0))
            else $error("zero operand gave nonzero product");
        // R4
        unit_a_chk: assert (!(op_a == W'(1)) || (prod == {{W{1'b0}}, op_b}))
            else $error("multiply by one (a) wrong");
        // R4
        unit_b_chk: assert (!(op_b == W'(1)) || (prod == {{W{1'b0}}, op_a}))
            else $error("multiply by one (b) wrong");
        // R5
        low_bit_chk: assert (prod[0] == (op_a[0] & op_b[0]))
            else $error("product bit 0 wrong");
        // R6
        narrow_upper_chk: assert (!(((op_a >> H) == '0) && ((op_b >> H) == '0))
                                  || (prod[2*W-1:W] == '0))
            else $error("narrow operands set upper bits");
    end

endmodule

bind vedic_mul vedic_mul_chk #(.W(WIDTH)) chk_i (
    .op_a (op_a),
    .op_b (op_b),
    .prod (prod)
);

// File: tb/vedic_mul_tb_top.sv
`timescale 1ns/1ps
module vedic_mul_tb_top;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;
    bit          done   = 1'b0;

    logic [15:0] a16, b16;  logic [31:0] p16;
    logic [7:0]  a8,  b8;   logic [15:0] p8;
    logic [3:0]  a4,  b4;   logic [7:0]  p4;
    logic [1:0]  a2,  b2;   logic [3:0]  p2;

    vedic_mul #(.WIDTH(16)) dut_i  (.op_a(a16), .op_b(b16), .prod(p16));
    vedic_mul #(.WIDTH(8))  dut8_i (.op_a(a8),  .op_b(b8),  .prod(p8));
    vedic_mul #(.WIDTH(4))  dut4_i (.op_a(a4),  .op_b(b4),  .prod(p4));
    vedic_mul #(.WIDTH(2))  dut2_i (.op_a(a2),  .op_b(b2),  .prod(p2));

    function automatic logic [63:0] ref_mul(input logic [31:0] x, input logic [31:0] y);
        return 64'(x) * 64'(y);
    endfunction

    function automatic logic [3:0] ref_cell(input logic [1:0] x, input logic [1:0] y);
        logic q0, q1, c1, q2, q3;
        q0 = x[0] & y[0];
        q1 = (x[1] & y[0]) ^ (x[0] & y[1]);
        c1 = (x[1] & y[0]) & (x[0] & y[1]);
        q2 = (x[1] & y[1]) ^ c1;
        q3 = (x[1] & y[1]) & c1;
        return {q3, q2, q1, q0};
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic drive16(input logic [15:0] x, input logic [15:0] y);
        @(negedge clk);
        a16 = x; b16 = y;
        #1;
    endtask

    initial begin
        a16 = '0; b16 = '0; a8 = '0; b8 = '0; a4 = '0; b4 = '0; a2 = '0; b2 = '0;
        void'($urandom(32'd20240917));
        #1;
        // R3: initial zero operands
        check("R3 idle", {32'd0, p16}, 64'd0);

        // R7: saturated carries
        drive16(16'hFFFF, 16'hFFFF);
        check("R7 max*max", {32'd0, p16}, 64'hFFFE0001);
        drive16(16'hFFFF, 16'h8001);
        check("R7 carry", {32'd0, p16}, ref_mul(32'hFFFF, 32'h8001));

        // R3 / R4 directed
        drive16(16'h0000, 16'hBEEF);
        check("R3 a=0", {32'd0, p16}, 64'd0);
        drive16(16'h1234, 16'h0000);
        check("R3 b=0", {32'd0, p16}, 64'd0);
        drive16(16'h0001, 16'hCAFE);
        check("R4 a=1", {32'd0, p16}, 64'h0000CAFE);
        drive16(16'hF00D, 16'h0001);
        check("R4 b=1", {32'd0, p16}, 64'h0000F00D);

        // R2: two operand changes with no clock edge between them
        @(negedge clk);
        a16 = 16'hFFFF; b16 = 16'hFFFF; #0.5;
        a16 = 16'h0003; b16 = 16'h0005; #0.5;
        check("R2 no state", {32'd0, p16}, 64'd15);

        // R1 / R5 random full width
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] x, y;
            x = 16'($urandom); y = 16'($urandom);
            if (i % 8 == 0) x = x | 16'hFF00;
            drive16(x, y);
            check("R1 random", {32'd0, p16}, ref_mul(32'(x), 32'(y)));
            check("R5 bit0", {63'd0, p16[0]}, {63'd0, x[0] & y[0]});
        end

        // R6: operands below 2^8
        for (int i = 0; i < 300; i++) begin
            logic [15:0] x, y;
            x = {8'h00, 8'($urandom)}; y = {8'h00, 8'($urandom)};
            drive16(x, y);
            check("R6 narrow upper", {48'd0, p16[31:16]}, 64'd0);
        end

        // R9: base cell exhaustive
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            a2 = 2'(i >> 2); b2 = 2'(i); #1;
            check("R9 cell", {60'd0, p2}, {60'd0, ref_cell(a2, b2)});
            check("R9 value", {60'd0, p2}, ref_mul(32'(a2), 32'(b2)));
        end

        // R8: exhaustive 4x4
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            a4 = 4'(i >> 4); b4 = 4'(i); #1;
            check("R8 w4", {56'd0, p4}, ref_mul(32'(a4), 32'(b4)));
        end

        // R8: exhaustive 8x8
        for (int i = 0; i < 65536; i++) begin
            @(negedge clk);
            a8 = 8'(i >> 8); b8 = 8'(i); #1;
            check("R8 w8", {48'd0, p8}, ref_mul(32'(a8), 32'(b8)));
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule